// File: doc/BRIEF.md
# Streaming Hilbert Transformer with Matched In-Phase Path

This block turns a real stream of signed fixed-point samples into a quadrature pair. The quadrature output is an FIR Hilbert approximation. It shifts every positive-frequency component by -90 degrees and every negative-frequency component by +90 degrees. The in-phase output is the same input, delayed so that it lines up in time with the filter's group delay. The pair can feed a phasing-method single-sideband demodulator or any other I/Q stage directly.

The impulse response has an odd tap count N, with (N-1)/2 also odd. It is antisymmetric about a zero centre tap, and every tap at an odd offset from the centre's neighbours (all odd indices) is zero. The datapath never touches those zero taps. Each antisymmetric pair of nonzero taps is folded by a pre-subtractor, so the filter spends only (N+1)/4 multipliers. Coefficients are a compile-time parameter array in signed Q1.(COEF_W-1) format. The pipeline has four register stages: delay line, pre-subtract, multiply, and sum/round/saturate.

Top module: `hilbert_fir`

## Requirements
- R1: A synchronous reset clears the delay line and all pipeline state. While reset is applied and afterwards, out_vld, out_i and out_q read 0 until new valid samples have passed through. Samples that arrive after reset see zeros as their history.
- R2: out_i equals the input sample accepted (N-1)/2 valid samples earlier, which is 5 with the default N = 11. It has the same signed DATA_W-bit format as the input.
- R3: out_q equals sum over k of COEFS[k] * x[n-k], divided by 2^(COEF_W-1) with round-half-up. Here x[n-k] are the last N accepted samples, newest at k = 0. The default COEFS, index 0 to 10, are -4172, 0, -6954, 0, -20861, 0, 20861, 0, 6954, 0, 4172.
- R4: out_vld is high in exactly the cycle that follows, by 4 clock cycles, a cycle with in_vld high, and in no other cycle. Each accepted sample yields exactly one output pair.
- R5: Cycles with in_vld low do not advance the delay line, and in_data is ignored on those cycles. While out_vld is low, out_i and out_q hold their last values.
- R6: A quadrature result beyond the signed DATA_W-bit range is clamped to 32767 or -32768 with the default width.
- R7: For an in-band tone, the outputs keep the quadrature relation. A cosine input gives a sine on out_q relative to out_i, and a sine input gives a negated cosine. At a normalised frequency of 1/8 the error is within 5 % of the tone amplitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_vld | output | 1 | Output pair strobe |
| out_i | output | DATA_W | In-phase output (delayed input) |
| out_q | output | DATA_W | Quadrature output (filtered, rounded, saturated) |

## Verification
The assertions assume that in_vld stays low while reset is high, so no sample is accepted and then dropped by the reset. They also assume that in_vld is a clean, known level at every sampling edge. The stimulus satisfies both conditions. It deasserts in_vld before every reset, including the mid-stream one, and it drives inputs only on falling edges. Idle cycles between samples carry a junk value on in_data, which shows that only strobed data enters the history.

// File: rtl/hilb_pkg.sv
package hilb_pkg;

    // Register stages from input capture to output register.
    localparam int HILB_STAGES = 4;

    // Number of folded (antisymmetric, nonzero) tap pairs.
    function automatic int hilb_pair_count(input int ntaps);
        return (ntaps + 1) / 4;
    endfunction

    // Index of the centre tap, which is also the in-phase delay.
    function automatic int hilb_centre(input int ntaps);
        return (ntaps - 1) / 2;
    endfunction

endpackage

// File: rtl/hilb_delay_line.sv
module hilb_delay_line #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_vld,
    input  logic [DATA_W-1:0]            in_data,
    output logic                         line_vld,
    output logic [NTAPS-1:0][DATA_W-1:0] line
);

    typedef struct packed {
        logic [NTAPS-1:0][DATA_W-1:0] taps;
        logic                         vld;
    } dl_state_t;

    dl_state_t st_d, st_q;

    // The history moves only when a sample is strobed in.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            for (int k = NTAPS - 1; k > 0; k--) begin
                st_d.taps[k] = st_q.taps[k-1];
            end
            st_d.taps[0] = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_vld = st_q.vld;
    assign line     = st_q.taps;

endmodule

// File: rtl/hilb_presub.sv
module hilb_presub #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 11
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          line_vld,
    input  logic [NTAPS-1:0][DATA_W-1:0]                  line,
    output logic                                          pair_vld,
    output logic [hilb_pkg::hilb_pair_count(NTAPS)-1:0][DATA_W:0] pair_diff,
    output logic [DATA_W-1:0]                             pair_mid
);

    import hilb_pkg::*;

    localparam int NPAIR = hilb_pair_count(NTAPS);
    localparam int CTR   = hilb_centre(NTAPS);

    typedef struct packed {
        logic [NPAIR-1:0][DATA_W:0] diff;
        logic [DATA_W-1:0]          mid;
        logic                       vld;
    } ps_state_t;

    ps_state_t                  st_d, st_q;
    logic [NPAIR-1:0][DATA_W:0] diff_w;
    logic                       unused_taps;

    // Fold each antisymmetric pair: newer even tap minus its mirror.
    for (genvar j = 0; j < NPAIR; j++) begin : g_fold
        localparam int NEAR = 2 * j;
        localparam int FAR  = NTAPS - 1 - 2 * j;
        assign diff_w[j] = $signed({line[NEAR][DATA_W-1], line[NEAR]})
                         - $signed({line[FAR][DATA_W-1], line[FAR]});
    end

    // Odd-index taps carry zero weight; only the centre one is reused.
    assign unused_taps = ^line;

    always_comb begin
        st_d     = st_q;
        st_d.vld = line_vld;
        if (line_vld) begin
            st_d.diff = diff_w;
            st_d.mid  = line[CTR];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_vld  = st_q.vld;
    assign pair_diff = st_q.diff;
    assign pair_mid  = st_q.mid;

endmodule

// File: rtl/hilb_mac.sv
module hilb_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 11,
    parameter logic signed [COEF_W-1:0] COEFS [NTAPS] = '{NTAPS{'0}}
) (
    input  logic                                                  clk,
    input  logic                                                  rst,
    input  logic                                                  pair_vld,
    input  logic [hilb_pkg::hilb_pair_count(NTAPS)-1:0][DATA_W:0] pair_diff,
    input  logic [DATA_W-1:0]                                     pair_mid,
    output logic                                                  out_vld,
    output logic [DATA_W-1:0]                                     out_i,
    output logic [DATA_W-1:0]                                     out_q
);

    import hilb_pkg::*;

    localparam int NPAIR  = hilb_pair_count(NTAPS);
    localparam int FRAC   = COEF_W - 1;
    localparam int PROD_W = DATA_W + 1 + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NPAIR) + 1;

    localparam logic signed [ACC_W-1:0] RND_ADD = ACC_W'(64'sd1 <<< (FRAC - 1));
    localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] OUT_MIN = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

    typedef struct packed {
        logic [NPAIR-1:0][PROD_W-1:0] prod;
        logic [DATA_W-1:0]            p_mid;
        logic                         p_vld;
        logic [DATA_W-1:0]            o_i;
        logic [DATA_W-1:0]            o_q;
        logic                         o_vld;
    } mac_state_t;

    mac_state_t                   st_d, st_q;
    logic [NPAIR-1:0][PROD_W-1:0] prod_w;
    logic signed [ACC_W-1:0]      acc;
    logic signed [ACC_W-1:0]      rnd;
    logic signed [ACC_W-1:0]      shf;
    logic [DATA_W-1:0]            q_sat;

    // One multiplier per folded pair, weight taken from the even tap.
    for (genvar j = 0; j < NPAIR; j++) begin : g_mul
        localparam logic signed [COEF_W-1:0] CF = COEFS[2*j];
        assign prod_w[j] = PROD_W'($signed(pair_diff[j])) * PROD_W'(CF);
    end

    always_comb begin
        st_d       = st_q;

        // Stage: register products.
        st_d.p_vld = pair_vld;
        if (pair_vld) begin
            st_d.prod  = prod_w;
            st_d.p_mid = pair_mid;
        end

        // Stage: full-width sum, round half up, clamp.
        acc = '0;
        for (int j = 0; j < NPAIR; j++) begin
            acc = acc + ACC_W'($signed(st_q.prod[j]));
        end
        rnd = acc + RND_ADD;
        shf = rnd >>> FRAC;
        if (shf > OUT_MAX) begin
            q_sat = OUT_MAX[DATA_W-1:0];
        end else if (shf < OUT_MIN) begin
            q_sat = OUT_MIN[DATA_W-1:0];
        end else begin
            q_sat = shf[DATA_W-1:0];
        end

        st_d.o_vld = st_q.p_vld;
        if (st_q.p_vld) begin
            st_d.o_i = st_q.p_mid;
            st_d.o_q = q_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.o_vld;
    assign out_i   = st_q.o_i;
    assign out_q   = st_q.o_q;

endmodule

// File: rtl/hilbert_fir.sv
module hilbert_fir #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 11,
    parameter logic signed [COEF_W-1:0] COEFS [NTAPS] = '{
        -16'sd4172,  16'sd0, -16'sd6954, 16'sd0, -16'sd20861, 16'sd0,
         16'sd20861, 16'sd0,  16'sd6954, 16'sd0,  16'sd4172
    }
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);

    import hilb_pkg::*;

    localparam int NPAIR   = hilb_pair_count(NTAPS);
    localparam int LATENCY = HILB_STAGES;

    // Structure guard: odd tap count with an odd half-length.
    if ((NTAPS % 4) != 3) begin : g_bad_taps
        $error("hilbert_fir: NTAPS must satisfy NTAPS mod 4 == 3");
    end

    logic                         line_vld;
    logic [NTAPS-1:0][DATA_W-1:0] line;
    logic                         pair_vld;
    logic [NPAIR-1:0][DATA_W:0]   pair_diff;
    logic [DATA_W-1:0]            pair_mid;

    hilb_delay_line #(
        .DATA_W (DATA_W),
        .NTAPS  (NTAPS)
    ) dl_i (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_data  (in_data),
        .line_vld (line_vld),
        .line     (line)
    );

    hilb_presub #(
        .DATA_W (DATA_W),
        .NTAPS  (NTAPS)
    ) ps_i (
        .clk       (clk),
        .rst       (rst),
        .line_vld  (line_vld),
        .line      (line),
        .pair_vld  (pair_vld),
        .pair_diff (pair_diff),
        .pair_mid  (pair_mid)
    );

    hilb_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .NTAPS  (NTAPS),
        .COEFS  (COEFS)
    ) mac_i (
        .clk       (clk),
        .rst       (rst),
        .pair_vld  (pair_vld),
        .pair_diff (pair_diff),
        .pair_mid  (pair_mid),
        .out_vld   (out_vld),
        .out_i     (out_i),
        .out_q     (out_q)
    );

endmodule

// File: rtl/hilbert_fir_chk.sv
module hilbert_fir_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_i,
    input logic [DATA_W-1:0] out_q
);

    // Cycles since reset release, saturating at the pipeline depth.
    logic [2:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (since_q != 3'd4) begin
            since_q <= since_q + 3'd1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!out_vld && out_i == '0 && out_q == '0)); // R1

    AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (rst)
        (since_q == 3'd4 && $past(in_vld, 4)) |-> out_vld); // R4

    AST_LATENCY_BWD: assert property (@(posedge clk) disable iff (rst)
        (since_q == 3'd4 && out_vld) |-> $past(in_vld, 4)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (since_q != 3'd0 && !out_vld) |-> ($stable(out_i) && $stable(out_q))); // R5

endmodule

bind hilbert_fir hilbert_fir_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_i   (out_i),
    .out_q   (out_q)
);

// File: tb/hilbert_fir_tb_top.sv
module hilbert_fir_tb_top;

    localparam int    NT   = 11;
    localparam int    CTR  = 5;
    localparam int    LAT  = 4;
    localparam int    WDOG = 50000;
    localparam real   PI   = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_vld;
    logic [15:0] out_i;
    logic [15:0] out_q;

    always #4 clk = ~clk;   // 125 MHz

    hilbert_fir dut_i (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_data (in_data),
        .out_vld (out_vld),
        .out_i   (out_i),
        .out_q   (out_q)
    );

    typedef struct {
        int    cyc;
        int    ei;
        int    eq;
        bit    ana_en;
        int    ana;
        int    tol;
        string tag;
    } exp_t;

    exp_t expq[$];
    exp_t e;
    int   hc[NT] = '{-4172, 0, -6954, 0, -20861, 0, 20861, 0, 6954, 0, 4172};
    int   hist[NT];
    int   cyc = 0;
    int   total = 0;
    int   fails = 0;
    int   last_i = 0;
    int   last_q = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int clamp16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Driver: apply one valid sample and queue the model's result.
    task automatic drive(input int x, input bit ana_en, input int ana, input int tol, input string tag);
        longint acc;
        exp_t   it;
        @(negedge clk);
        in_vld  = 1'b1;
        in_data = 16'(x);
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        acc = 0;
        for (int k = 0; k < NT; k++) acc += longint'(hc[k]) * longint'(hist[k]);
        acc = (acc + 64'sd16384) >>> 15;
        it.cyc    = cyc + LAT;
        it.ei     = hist[CTR];
        it.eq     = clamp16(acc);
        it.ana_en = ana_en;
        it.ana    = ana;
        it.tol    = tol;
        it.tag    = tag;
        expq.push_back(it);
    endtask

    task automatic gap();
        @(negedge clk);
        in_vld  = 1'b0;
        in_data = 16'h5A5A;   // junk that must not enter the history
    endtask

    task automatic tone(input real f, input int amp, input int n_smp, input string tag);
        for (int n = 0; n < n_smp; n++) begin
            drive($rtoi(amp * $cos(2.0 * PI * f * n)), 1'b0, 0, 0, tag);
            if (n % 3 == 2) gap();
        end
        gap();
    endtask

    // Monitor: compare every produced pair against the queue.
    always @(negedge clk) begin
        if (rst) begin
            last_i = 0;
            last_q = 0;
        end else begin
            if (out_vld) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 output without input", 1, 0);
                end else begin
                    e = expq.pop_front();
                    chk(cyc == e.cyc, {"R4 latency ", e.tag}, cyc, e.cyc);
                    chk(int'($signed(out_i)) == e.ei, {"R2 in-phase ", e.tag}, int'($signed(out_i)), e.ei);
                    chk(int'($signed(out_q)) == e.eq, {"R3 quadrature ", e.tag}, int'($signed(out_q)), e.eq);
                    if (e.ana_en) begin
                        int d;
                        d = int'($signed(out_q)) - e.ana;
                        if (d < 0) d = -d;
                        chk(d <= e.tol, {"R7 phase ", e.tag}, int'($signed(out_q)), e.ana);
                    end
                end
            end else begin
                chk(int'($signed(out_i)) == last_i && int'($signed(out_q)) == last_q,
                    "R5 idle hold", int'($signed(out_q)), last_q);
            end
            last_i = int'($signed(out_i));
            last_q = int'($signed(out_q));
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        if (cyc == WDOG) begin
            total++;
            fails++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NT; k++) hist[k] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(out_vld == 1'b0, "R1 reset valid", int'(out_vld), 0);
        chk(out_i == '0, "R1 reset in-phase", int'($signed(out_i)), 0);
        chk(out_q == '0, "R1 reset quadrature", int'($signed(out_q)), 0);

        // R3: impulse response, with gaps (R5)
        drive(10000, 1'b0, 0, 0, "impulse");
        for (int n = 0; n < 12; n++) begin
            drive(0, 1'b0, 0, 0, "impulse");
            if (n % 2 == 0) gap();
        end
        gap();

        // R2/R3/R5: tones at several in-band frequencies
        tone(1.0 / 16.0, 12000, 40, "tone f/16");
        tone(3.0 / 16.0, 9000, 40, "tone 3f/16");
        tone(0.25, 15000, 40, "tone f/4");

        // R7: cosine -> sine, sine -> -cosine at f = 1/8
        for (int n = 0; n < 48; n++) begin
            real w;
            w = 2.0 * PI / 8.0;
            drive($rtoi(12000.0 * $cos(w * n)), n >= 10,
                  $rtoi(12000.0 * $sin(w * (n - CTR))), 602, "cos->sin");
        end
        for (int n = 0; n < 48; n++) begin
            real w;
            w = 2.0 * PI / 8.0;
            drive($rtoi(12000.0 * $sin(w * n)), n >= 10,
                  -$rtoi(12000.0 * $cos(w * (n - CTR))), 602, "sin->-cos");
        end
        gap();

        // R6: full-scale steps drive the sum past both rails
        for (int n = 0; n < 12; n++) drive(-32768, 1'b0, 0, 0, "R6 step low");
        for (int n = 0; n < 12; n++) drive(32767, 1'b0, 0, 0, "R6 step high");
        for (int n = 0; n < 12; n++) drive(-32768, 1'b0, 0, 0, "R6 step low");
        gap();
        repeat (LAT + 2) @(negedge clk);

        // R1: reset mid-stream clears the history
        drive(20000, 1'b0, 0, 0, "pre-reset");
        drive(-15000, 1'b0, 0, 0, "pre-reset");
        drive(7000, 1'b0, 0, 0, "pre-reset");
        gap();
        @(negedge clk);
        rst = 1'b1;
        expq.delete();
        for (int k = 0; k < NT; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1 mid reset valid", int'(out_vld), 0);
        chk(out_q == '0, "R1 mid reset quadrature", int'($signed(out_q)), 0);
        drive(5000, 1'b0, 0, 0, "R1 post-reset");
        for (int n = 0; n < 11; n++) drive(0, 1'b0, 0, 0, "R1 post-reset");
        gap();
        repeat (LAT + 2) @(negedge clk);

        chk(expq.size() == 0, "R4 all outputs delivered", expq.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule